// File: doc/BRIEF.md
# Low-Power Idle Mode Controller

This block sequences the clock enables of a small microcontroller core between two run modes and two idle modes. In a run mode both the CPU and the peripherals are clocked, either from the primary oscillator or from a low-speed secondary oscillator. The source is chosen by a 2-bit clock-select field together with an enable bit for the secondary oscillator. In an idle mode only the CPU clock is gated. The peripherals keep running from whichever source was active when idle was entered.

An idle mode is entered when a sleep strobe arrives while the idle-enable control bit is set. A sleep strobe with idle-enable clear is handed unchanged to an external full-sleep sequencer through a separate output. Any of the wake-event lines ends an idle mode. The CPU clock then stays off for a fixed, parameterised clock-switch delay before execution resumes on the same source. When the secondary oscillator is in use, the primary oscillator is shut down and the status flags report it. While the secondary oscillator has not yet reported running, all clock enables are held off.

Top module: `idle_mode_ctrl`

## Requirements
- R1: A synchronous active-high reset selects primary run: cpu_clk_en=1, per_clk_en=1, per_clk_sec=0, pri_osc_en=1, pri_stable=1, sec_active=0.
- R2: In a run mode, a sleep_stb with idle_en=1 gates the CPU clock from the next cycle. The peripheral clock stays enabled on the current source, and the primary oscillator stays enabled when that source is primary.
- R3: In a run mode, clk_sel=2'b01 with sec_osc_en=1 selects the secondary source from the next cycle: per_clk_sec=1, pri_osc_en=0, pri_stable=0, sec_active=1. Any other clk_sel value (2'b00, 2'b10, 2'b11) selects the primary source, with those four outputs inverted.
- R4: clk_sel=2'b01 with sec_osc_en=0 keeps the primary source, so a following sleep with idle_en=1 enters primary idle and never secondary idle.
- R5: While the secondary source is selected and sec_osc_ready=0, per_clk_en and cpu_clk_en are 0 in the same cycle.
- R6: A sleep_stb with idle_en=1 while the secondary source is selected enters secondary idle: cpu_clk_en=0, and the peripherals stay clocked from the secondary source (per_clk_sec=1, pri_osc_en=0).
- R7: If any wake_evt bit is 1 at the clock edge that ends an idle cycle, cpu_clk_en stays 0 for exactly WAKE_DLY further cycles and is 1 after that.
- R8: Idle entry, the wake delay and the return to run do not change the source or the status flags. In primary idle, pri_stable stays 1 throughout.
- R9: wake_evt has no effect in a run mode or during the wake delay. sleep_stb has no effect during idle or the wake delay.
- R10: In a run mode, sleep_out equals sleep_stb when idle_en=0 and is 0 otherwise. The mode is unchanged. sleep_out is 0 in idle and during the wake delay.
- R11: Changes to clk_sel or sec_osc_en during idle or the wake delay do not change the source. They take effect only once back in a run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_stb | input | 1 | One-cycle strobe from the sleep instruction |
| idle_en | input | 1 | Sleep goes to idle rather than full sleep |
| clk_sel | input | 2 | Clock-select field, 2'b01 = secondary |
| sec_osc_en | input | 1 | Secondary oscillator enable bit |
| sec_osc_ready | input | 1 | Secondary oscillator reports running |
| wake_evt | input | NWAKE | Wake-event lines |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| per_clk_sec | output | 1 | Peripheral/CPU source, 1 = secondary |
| pri_osc_en | output | 1 | Primary oscillator enable |
| pri_stable | output | 1 | Status: primary clock stable and in use |
| sec_active | output | 1 | Status: secondary clock in use |
| sleep_out | output | 1 | Sleep request passed to the full-sleep sequencer |

## Verification
The assertions assume that sleep_stb is a single-cycle strobe and that the inputs change only between clock edges. They require nothing of how wake_evt, clk_sel or sec_osc_en are sequenced, because the block must tolerate any order of those. The stimulus drives every input on the falling edge, holds it across the rising edge and keeps sleep strobes to one cycle. It also deliberately sends wake events, sleep strobes and clock-select changes in modes where they must be ignored, so the idle and wake-delay properties are tested under their hardest legal input.

// File: rtl/idle_mode_ctrl.sv
module idle_mode_ctrl #(
  parameter int WAKE_DLY = 8,
  parameter int NWAKE    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_stb,
  input  logic             idle_en,
  input  logic [1:0]       clk_sel,
  input  logic             sec_osc_en,
  input  logic             sec_osc_ready,
  input  logic [NWAKE-1:0] wake_evt,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             per_clk_sec,
  output logic             pri_osc_en,
  output logic             pri_stable,
  output logic             sec_active,
  output logic             sleep_out
);
  localparam int CW = (WAKE_DLY > 1) ? $clog2(WAKE_DLY) : 1;

  typedef enum logic [1:0] {M_RUN, M_IDLE, M_WAKE} mode_t;

  mode_t         mode;
  logic [CW-1:0] dly;
  logic          src_sec;
  logic          flag_pri;
  logic          flag_sec;

  wire want_sec = (clk_sel == 2'b01) && sec_osc_en;
  wire clk_ok   = !src_sec || sec_osc_ready;
  wire in_run   = (mode == M_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= M_RUN;
      dly      <= '0;
      src_sec  <= 1'b0;
      flag_pri <= 1'b1;
      flag_sec <= 1'b0;
    end else begin
      unique case (mode)
        M_RUN: begin
          src_sec  <= want_sec;
          flag_pri <= !want_sec;
          flag_sec <= want_sec;
          if (sleep_stb && idle_en) mode <= M_IDLE;
        end
        M_IDLE: begin
          if (|wake_evt) begin
            mode <= M_WAKE;
            dly  <= CW'(WAKE_DLY - 1);
          end
        end
        M_WAKE: begin
          if (dly == '0) mode <= M_RUN;
          else           dly  <= dly - 1'b1;
        end
        default: mode <= M_RUN;
      endcase
    end
  end

  assign per_clk_en  = clk_ok;
  assign cpu_clk_en  = in_run && clk_ok;
  assign per_clk_sec = src_sec;
  assign pri_osc_en  = !src_sec;
  assign pri_stable  = flag_pri;
  assign sec_active  = flag_sec;
  assign sleep_out   = in_run && sleep_stb && !idle_en;

  logic [CW:0] wake_seen;
  always_ff @(posedge clk) begin
    if (rst || mode == M_IDLE) wake_seen <= '0;
    else if (mode == M_WAKE)   wake_seen <= wake_seen + 1'b1;
  end

  a_r2_idle_entry: assert property (@(posedge clk) disable iff (rst)
    (in_run && sleep_stb && idle_en) |=> (!cpu_clk_en && mode == M_IDLE));

  a_r3_flags_agree: assert property (@(posedge clk) disable iff (rst)
    (pri_stable != sec_active) && (sec_active == per_clk_sec));

  a_r5_hold_off: assert property (@(posedge clk) disable iff (rst)
    (per_clk_sec && !sec_osc_ready) |-> (!per_clk_en && !cpu_clk_en));

  a_r7_wake_len: assert property (@(posedge clk) disable iff (rst)
    (in_run && $past(mode) == M_WAKE) |-> (wake_seen == (CW+1)'(WAKE_DLY)));

  a_r9_delay_runs: assert property (@(posedge clk) disable iff (rst)
    (mode == M_WAKE && dly != '0) |=> (mode == M_WAKE));

  a_r10_pass_stays: assert property (@(posedge clk) disable iff (rst)
    sleep_out |=> (mode == M_RUN));

  a_r11_src_hold: assert property (@(posedge clk) disable iff (rst)
    (!in_run) |=> (src_sec == $past(src_sec) && pri_stable == $past(pri_stable)));
endmodule

// File: tb/idle_mode_ctrl_bench.sv
module idle_mode_ctrl_bench;
  localparam int DLY = 8;
  localparam int NW  = 4;

  logic clk = 1'b0;
  logic rst, sleep_stb, idle_en, sec_osc_en, sec_osc_ready;
  logic [1:0] clk_sel;
  logic [NW-1:0] wake_evt;
  logic cpu_clk_en, per_clk_en, per_clk_sec, pri_osc_en, pri_stable, sec_active, sleep_out;

  always #2.5 clk = ~clk;

  idle_mode_ctrl #(.WAKE_DLY(DLY), .NWAKE(NW)) u_idle_mode_ctrl (
    .clk(clk), .rst(rst), .sleep_stb(sleep_stb), .idle_en(idle_en),
    .clk_sel(clk_sel), .sec_osc_en(sec_osc_en), .sec_osc_ready(sec_osc_ready),
    .wake_evt(wake_evt), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .per_clk_sec(per_clk_sec), .pri_osc_en(pri_osc_en), .pri_stable(pri_stable),
    .sec_active(sec_active), .sleep_out(sleep_out));

  int total = 0, bad = 0, cycles = 0;
  string req = "R1";
  int m_mode = 0;
  int m_cnt  = 0;
  bit m_src  = 0;
  bit done   = 0;

  task automatic chk(string r, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", r, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit ok;
    ok = !m_src || sec_osc_ready;
    chk(req, cpu_clk_en,  (m_mode == 0) && ok, "cpu_clk_en");
    chk(req, per_clk_en,  ok, "per_clk_en");
    chk(req, per_clk_sec, m_src, "per_clk_sec");
    chk(req, pri_osc_en,  !m_src, "pri_osc_en");
    chk(req, pri_stable,  !m_src, "pri_stable");
    chk(req, sec_active,  m_src, "sec_active");
    chk(req, sleep_out,   (m_mode == 0) && sleep_stb && !idle_en, "sleep_out");
  endtask

  task automatic model_edge();
    if (rst) begin
      m_mode = 0; m_src = 0; m_cnt = 0;
    end else if (m_mode == 0) begin
      m_src = (clk_sel == 2'b01) && sec_osc_en;
      if (sleep_stb && idle_en) m_mode = 1;
    end else if (m_mode == 1) begin
      if (wake_evt != 0) begin m_mode = 2; m_cnt = DLY; end
    end else begin
      m_cnt--;
      if (m_cnt == 0) m_mode = 0;
    end
  endtask

  task automatic step();
    #1 compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    sleep_stb = 1'b0;
    wake_evt  = '0;
  endtask

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<=50000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : stim
    int n;
    logic [15:0] lf;
    rst = 1'b1; sleep_stb = 0; idle_en = 0; clk_sel = 2'b00;
    sec_osc_en = 0; sec_osc_ready = 0; wake_evt = '0;
    @(negedge clk);
    step(); step();
    rst = 1'b0;
    req = "R1"; step();
    chk("R1", cpu_clk_en, 1'b1, "reset cpu");
    chk("R1", pri_stable, 1'b1, "reset pri_stable");

    // R10 pass-through of sleep with idle disabled
    req = "R10"; sleep_stb = 1; #1 chk("R10", sleep_out, 1'b1, "sleep_out"); step();
    chk("R10", cpu_clk_en, 1'b1, "no mode change");

    // R9 wake ignored in run
    req = "R9"; wake_evt = 4'b0100; step();
    chk("R9", cpu_clk_en, 1'b1, "wake in run");

    // R2 primary idle, R8 flag kept
    req = "R2"; idle_en = 1; sleep_stb = 1; step();
    chk("R2", cpu_clk_en, 1'b0, "cpu off in idle");
    chk("R2", per_clk_en, 1'b1, "per on in idle");
    req = "R8"; idle_cycles(3);
    chk("R8", pri_stable, 1'b1, "pri_stable in idle");
    req = "R9"; sleep_stb = 1; step();
    chk("R9", sleep_out, 1'b0, "sleep in idle");
    // R7 wake delay length, with R9 wake inside delay
    req = "R7"; wake_evt = 4'b0001; step();
    n = 0;
    while (!cpu_clk_en && n < 100) begin
      if (n == 2) wake_evt = 4'b1000;
      if (n == 3) sleep_stb = 1;
      step(); n++;
    end
    total++;
    if (n != DLY) begin bad++; $display("FAIL R7 wake delay actual=%0d expected=%0d", n, DLY); end
    chk("R8", pri_stable, 1'b1, "pri_stable after wake");

    // R4 secondary requested without enable
    req = "R4"; clk_sel = 2'b01; sec_osc_en = 0; step();
    chk("R4", per_clk_sec, 1'b0, "stays primary");
    sleep_stb = 1; step();
    chk("R4", per_clk_sec, 1'b0, "primary idle");
    chk("R4", pri_osc_en, 1'b1, "pri osc on");
    wake_evt = 4'b0010; step(); idle_cycles(DLY);

    // R3 switch to secondary, R5 hold-off until ready
    req = "R5"; sec_osc_en = 1; sec_osc_ready = 0; step();
    chk("R3", sec_active, 1'b1, "sec_active");
    chk("R3", pri_stable, 1'b0, "pri_stable cleared");
    chk("R5", per_clk_en, 1'b0, "per held");
    idle_cycles(2);
    req = "R3"; sec_osc_ready = 1; #1 chk("R5", cpu_clk_en, 1'b1, "cpu after ready"); step();

    // R6 secondary idle; R11 select changes while idle
    req = "R6"; sleep_stb = 1; step();
    chk("R6", cpu_clk_en, 1'b0, "cpu off");
    chk("R6", per_clk_sec, 1'b1, "per on secondary");
    req = "R11"; clk_sel = 2'b00; sec_osc_en = 0; idle_cycles(2);
    chk("R11", per_clk_sec, 1'b1, "held in idle");
    wake_evt = 4'b0100; step(); idle_cycles(DLY - 1);
    chk("R11", per_clk_sec, 1'b1, "held in delay");
    clk_sel = 2'b01; sec_osc_en = 1; step();
    chk("R8", per_clk_sec, 1'b1, "resume secondary");
    chk("R8", cpu_clk_en, 1'b1, "cpu resumed");

    req = "R3"; clk_sel = 2'b10; step();
    chk("R3", per_clk_sec, 1'b0, "sel 10 primary");
    clk_sel = 2'b11; step();
    chk("R3", pri_osc_en, 1'b1, "sel 11 primary");

    req = "R9"; lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      sleep_stb = (lf[3:0] == 4'h5);
      idle_en = lf[4] | lf[9];
      clk_sel = lf[6:5];
      sec_osc_en = lf[7] | lf[11];
      sec_osc_ready = lf[8] | lf[12] | lf[1];
      wake_evt = (lf[15:13] == 3'b101) ? lf[3:0] : 4'b0;
      step();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule